// File: doc/BRIEF.md
# DRAM Page-Hit Traffic Generator

This block produces a stream of memory request descriptors for stress-testing a single-channel, single-rank DRAM controller. Each descriptor carries an address, a read/write flag and a fixed burst size. Requests come in runs. Every request in a run targets successive columns of the same DRAM page, so the run length sets the page-hit length the controller sees. The number of banks that receive traffic is also configurable, which sets how widely the traffic spreads across banks.

At the start of a run, the block draws four random values from an internal 32-bit Galois LFSR: an address inside a configured window, a bank, a column and a read/write choice. It then writes the bank and column into the address at positions that depend on the selected address-mapping mode. Descriptors leave through a valid/ready handshake. After each accepted descriptor the block waits a random number of idle cycles, within a configured range, before it offers the next one. Configuration is static while the generator is enabled.

Top module: `dram_hit_gen`

## Requirements
- R1: A run is `num_seq` consecutive accepted requests. `num_seq` is ceil(`cfg_stride_bytes` / block size), and it is 1 when the stride is zero or not larger than the block. Every request of a run carries the same direction, the same bank and the same row (the address bits above both fields), and its column is the previous column plus one.
- R2: The direction is chosen once per run. A `cfg_read_pct` of 0 always gives writes (`req_is_read`=0). A value of 100 always gives reads (`req_is_read`=1). Any other value gives a read when a random value in 0..100 is below the percentage.
- R3: The block offset bits [`cfg_block_log2`-1:0] of every address are zero. The row bits (bit `cfg_page_log2`+`cfg_bank_log2` and above) lie between those of `cfg_start_addr` and `cfg_end_addr`-1. `req_size` equals 2^`cfg_block_log2`.
- R4: The bank of the first request of a run lies in 0..`cfg_banks_used`-1. Its column lies in 0..(columns per page − `num_seq`), where columns per page is 2^(`cfg_page_log2`−`cfg_block_log2`).
- R5: With `cfg_map_sel`=1, the column field sits directly above the block offset and the bank field sits directly above the column field. Each later request of a run is the previous address plus one block.
- R6: With `cfg_map_sel`=0, the bank field (`cfg_bank_log2` bits) sits directly above the block offset and the column field sits above the bank field. Each later request of a run rewrites only the column field to its old value plus one, and leaves the bank bits unchanged.
- R7: Values 2 and 3 of `cfg_map_sel` behave exactly like value 1.
- R8: `cfg_err` is 1 when `cfg_banks_used` is 0, when it exceeds 2^`cfg_bank_log2`, or when `cfg_page_log2` < `cfg_block_log2`. While `cfg_err` is 1, `req_valid` never rises.
- R9: After each handshake, `req_valid` stays low for g+1 cycles, with g drawn from `cfg_gap_min`..`cfg_gap_max`.
- R10: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and `req_addr` and `req_is_read` hold their values.
- R11: During reset and after it, `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Enables descriptor generation |
| cfg_start_addr | input | ADDR_W | Inclusive lower bound of the address window |
| cfg_end_addr | input | ADDR_W | Exclusive upper bound of the address window |
| cfg_block_log2 | input | LOG_W | log2 of burst size in bytes |
| cfg_page_log2 | input | LOG_W | log2 of DRAM page size in bytes |
| cfg_bank_log2 | input | LOG_W | log2 of total bank count |
| cfg_banks_used | input | BANKS_W | Number of banks receiving traffic |
| cfg_stride_bytes | input | STRIDE_W | Bytes per run, sets the run length |
| cfg_read_pct | input | 7 | Read percentage, 0..100 |
| cfg_map_sel | input | 2 | Address mapping select |
| cfg_gap_min | input | GAP_W | Minimum idle gap in cycles |
| cfg_gap_max | input | GAP_W | Maximum idle gap in cycles |
| req_valid | output | 1 | Descriptor offered |
| req_ready | input | 1 | Descriptor accepted when high with valid |
| req_addr | output | ADDR_W | Request byte address |
| req_is_read | output | 1 | 1 = read, 0 = write |
| req_size | output | ADDR_W | Burst size in bytes |
| cfg_err | output | 1 | Configuration inconsistency flag |

## Verification
The bench builds the block with its default widths and sweeps a small geometry: block sizes of 4 and 8 bytes, 4 or 8 columns per page, 2 or 4 banks, one bank or all banks used, all four mapping selects and three strides. The strides give runs of one request and runs that fill a whole page. Because these fields are small, the random draws reach the edges of the bank and column ranges, and runs whose column range collapses to zero. Each configuration is paired with a gap range and a read percentage, and a repeating ready pattern exercises stalls in every configuration.

// File: rtl/dhg_pkg.sv
package dhg_pkg;

  localparam int unsigned RNG_W = 32;
  localparam logic [RNG_W-1:0] RNG_TAPS = 32'h8020_0003;

  typedef enum logic {
    MAP_BANK_LOW = 1'b0,
    MAP_COL_LOW  = 1'b1
  } map_e;

  function automatic logic [RNG_W-1:0] rng_rot(input logic [RNG_W-1:0] v,
                                               input int unsigned n);
    return (v >> n) | (v << (RNG_W - n));
  endfunction

endpackage

// File: rtl/dhg_cfg_decode.sv
module dhg_cfg_decode
  import dhg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LOG_W    = 5,
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned BANKS_W  = 8
) (
  input  logic [LOG_W-1:0]    block_log2,
  input  logic [LOG_W-1:0]    page_log2,
  input  logic [LOG_W-1:0]    bank_log2,
  input  logic [BANKS_W-1:0]  banks_used,
  input  logic [STRIDE_W-1:0] stride_bytes,
  input  logic [1:0]          map_sel,
  output logic [LOG_W-1:0]    col_bits,
  output logic [ADDR_W-1:0]   blk_bytes,
  output logic [ADDR_W-1:0]   cols,
  output logic [STRIDE_W-1:0] num_seq,
  output map_e                mode,
  output logic                cfg_err
);

  localparam int unsigned SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0]  stride_sum;
  logic [SUM_W-1:0]  stride_quo;
  logic [ADDR_W-1:0] total_banks;

  always_comb begin
    blk_bytes   = ADDR_W'(1) << block_log2;
    col_bits    = page_log2 - block_log2;
    cols        = ADDR_W'(1) << col_bits;
    stride_sum  = SUM_W'(stride_bytes) + SUM_W'(blk_bytes) - SUM_W'(1);
    stride_quo  = stride_sum >> block_log2;
    num_seq     = (stride_bytes == '0) ? STRIDE_W'(1) : STRIDE_W'(stride_quo);
    mode        = (map_sel == 2'd0) ? MAP_BANK_LOW : MAP_COL_LOW;
    total_banks = ADDR_W'(1) << bank_log2;
    cfg_err     = (banks_used == '0) ||
                  (ADDR_W'(banks_used) > total_banks) ||
                  (page_log2 < block_log2);
  end

endmodule

// File: rtl/dhg_lfsr.sv
module dhg_lfsr
  import dhg_pkg::*;
#(
  parameter logic [RNG_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [RNG_W-1:0] state
);

  logic [RNG_W-1:0] state_d;

  always_comb begin
    state_d = state;
    if (adv) begin
      state_d = (state >> 1) ^ ({RNG_W{state[0]}} & RNG_TAPS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (adv) begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/dhg_gap_timer.sv
module dhg_gap_timer
  import dhg_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RNG_W-1:0] rnd,
  input  logic [GAP_W-1:0] gap_min,
  input  logic [GAP_W-1:0] gap_max,
  output logic             done
);

  logic [GAP_W:0]   span;
  logic [GAP_W-1:0] pick;
  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    span   = (gap_max >= gap_min) ? ((GAP_W+1)'(gap_max) - (GAP_W+1)'(gap_min) + (GAP_W+1)'(1))
                                  : (GAP_W+1)'(1);
    pick   = gap_min + GAP_W'(rnd % RNG_W'(span));
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? pick : (cnt_q - GAP_W'(1));
    done   = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_GAP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_max >= gap_min) |-> (cnt_q <= gap_max)); // R9
  AST_GAP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (load && gap_max >= gap_min) |=> (cnt_q >= gap_min)); // R9

endmodule

// File: rtl/dhg_addr_shaper.sv
module dhg_addr_shaper
  import dhg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LOG_W    = 5,
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned BANKS_W  = 8
) (
  input  logic [RNG_W-1:0]    rnd,
  input  logic                first,
  input  logic [ADDR_W-1:0]   prev_addr,
  input  logic [ADDR_W-1:0]   win_lo,
  input  logic [ADDR_W-1:0]   win_hi,
  input  logic [ADDR_W-1:0]   blk_bytes,
  input  logic [LOG_W-1:0]    block_log2,
  input  logic [LOG_W-1:0]    col_bits,
  input  logic [LOG_W-1:0]    bank_log2,
  input  logic [ADDR_W-1:0]   cols,
  input  logic [BANKS_W-1:0]  banks_used,
  input  logic [STRIDE_W-1:0] num_seq,
  input  logic [6:0]          read_pct,
  input  map_e                mode,
  output logic [ADDR_W-1:0]   nxt_addr,
  output logic                nxt_read
);

  localparam int unsigned POS_W = LOG_W + 2;

  logic [ADDR_W-1:0] rnd_a, rnd_p, rnd_b, rnd_c;
  logic [ADDR_W-1:0] span_a, drawn, aligned;
  logic [ADDR_W-1:0] roll;
  logic [ADDR_W-1:0] bank_span, bank_v;
  logic [ADDR_W-1:0] col_span, col_v, cur_col;
  logic [ADDR_W-1:0] col_mask, bank_mask;
  logic [ADDR_W-1:0] fresh, step;
  logic [POS_W-1:0]  col_pos, bank_pos;

  always_comb begin
    rnd_a = ADDR_W'(rnd);
    rnd_p = ADDR_W'(rng_rot(rnd, 8));
    rnd_b = ADDR_W'(rng_rot(rnd, 16));
    rnd_c = ADDR_W'(rng_rot(rnd, 24));

    // window draw, then align down to a burst boundary
    span_a  = (win_hi > win_lo) ? (win_hi - win_lo) : ADDR_W'(1);
    drawn   = win_lo + (rnd_a % span_a);
    aligned = drawn & ~(blk_bytes - ADDR_W'(1));

    bank_span = (banks_used == '0) ? ADDR_W'(1) : ADDR_W'(banks_used);
    bank_v    = rnd_b % bank_span;
    col_span  = (ADDR_W'(num_seq) > cols) ? ADDR_W'(1)
                                          : (cols - ADDR_W'(num_seq) + ADDR_W'(1));
    col_v     = rnd_c % col_span;

    if (mode == MAP_COL_LOW) begin
      col_pos  = POS_W'(block_log2);
      bank_pos = POS_W'(block_log2) + POS_W'(col_bits);
    end else begin
      bank_pos = POS_W'(block_log2);
      col_pos  = POS_W'(block_log2) + POS_W'(bank_log2);
    end
    col_mask  = (cols - ADDR_W'(1)) << col_pos;
    bank_mask = ((ADDR_W'(1) << bank_log2) - ADDR_W'(1)) << bank_pos;

    fresh = (aligned & ~col_mask & ~bank_mask) |
            ((col_v << col_pos) & col_mask) |
            ((bank_v << bank_pos) & bank_mask);

    cur_col = (prev_addr >> col_pos) & (cols - ADDR_W'(1));
    if (mode == MAP_COL_LOW) begin
      step = prev_addr + blk_bytes;
    end else begin
      step = (prev_addr & ~col_mask) | (((cur_col + ADDR_W'(1)) << col_pos) & col_mask);
    end

    nxt_addr = first ? fresh : step;

    roll = rnd_p % ADDR_W'(101);
    if (read_pct == 7'd0) begin
      nxt_read = 1'b0;
    end else if (read_pct >= 7'd100) begin
      nxt_read = 1'b1;
    end else begin
      nxt_read = (roll < ADDR_W'(read_pct));
    end
  end

endmodule

// File: rtl/dram_hit_gen.sv
module dram_hit_gen
  import dhg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LOG_W    = 5,
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned BANKS_W  = 8,
  parameter int unsigned GAP_W    = 8,
  parameter logic [RNG_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_en,
  input  logic [ADDR_W-1:0]   cfg_start_addr,
  input  logic [ADDR_W-1:0]   cfg_end_addr,
  input  logic [LOG_W-1:0]    cfg_block_log2,
  input  logic [LOG_W-1:0]    cfg_page_log2,
  input  logic [LOG_W-1:0]    cfg_bank_log2,
  input  logic [BANKS_W-1:0]  cfg_banks_used,
  input  logic [STRIDE_W-1:0] cfg_stride_bytes,
  input  logic [6:0]          cfg_read_pct,
  input  logic [1:0]          cfg_map_sel,
  input  logic [GAP_W-1:0]    cfg_gap_min,
  input  logic [GAP_W-1:0]    cfg_gap_max,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic                req_is_read,
  output logic [ADDR_W-1:0]   req_size,
  output logic                cfg_err
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic [LOG_W-1:0]    col_bits;
  logic [ADDR_W-1:0]   blk_bytes;
  logic [ADDR_W-1:0]   cols;
  logic [STRIDE_W-1:0] num_seq;
  map_e                mode;
  logic [RNG_W-1:0]    rnd;
  logic                gap_done;
  logic [ADDR_W-1:0]   shaped_addr;
  logic                shaped_read;

  logic                valid_q, valid_d, valid_en;
  logic [ADDR_W-1:0]   addr_q;
  logic                read_q;
  logic [STRIDE_W-1:0] run_left_q, run_left_d;
  logic                run_en;
  logic                first, fire, hs;

  dhg_cfg_decode #(
    .ADDR_W(ADDR_W), .LOG_W(LOG_W), .STRIDE_W(STRIDE_W), .BANKS_W(BANKS_W)
  ) u_cfg (
    .block_log2  (cfg_block_log2),
    .page_log2   (cfg_page_log2),
    .bank_log2   (cfg_bank_log2),
    .banks_used  (cfg_banks_used),
    .stride_bytes(cfg_stride_bytes),
    .map_sel     (cfg_map_sel),
    .col_bits    (col_bits),
    .blk_bytes   (blk_bytes),
    .cols        (cols),
    .num_seq     (num_seq),
    .mode        (mode),
    .cfg_err     (cfg_err)
  );

  dhg_lfsr #(.SEED(SEED)) u_rng (
    .clk  (clk),
    .rst_n(rst_n_int),
    .adv  (hs),
    .state(rnd)
  );

  dhg_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (hs),
    .rnd    (rng_rot(rnd, 4) ^ rnd),
    .gap_min(cfg_gap_min),
    .gap_max(cfg_gap_max),
    .done   (gap_done)
  );

  dhg_addr_shaper #(
    .ADDR_W(ADDR_W), .LOG_W(LOG_W), .STRIDE_W(STRIDE_W), .BANKS_W(BANKS_W)
  ) u_shape (
    .rnd       (rnd),
    .first     (first),
    .prev_addr (addr_q),
    .win_lo    (cfg_start_addr),
    .win_hi    (cfg_end_addr),
    .blk_bytes (blk_bytes),
    .block_log2(cfg_block_log2),
    .col_bits  (col_bits),
    .bank_log2 (cfg_bank_log2),
    .cols      (cols),
    .banks_used(cfg_banks_used),
    .num_seq   (num_seq),
    .read_pct  (cfg_read_pct),
    .mode      (mode),
    .nxt_addr  (shaped_addr),
    .nxt_read  (shaped_read)
  );

  // next-state logic
  always_comb begin
    first    = (run_left_q == '0);
    fire     = gen_en && !cfg_err && !valid_q && gap_done;
    hs       = valid_q && req_ready;
    valid_en = fire || hs;
    valid_d  = fire;
    run_en   = (fire && first) || hs;
    run_left_d = (fire && first) ? num_seq : (run_left_q - STRIDE_W'(1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q <= '0;
    end else if (fire) begin
      addr_q <= shaped_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      read_q <= 1'b0;
    end else if (fire && first) begin
      read_q <= shaped_read;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      run_left_q <= '0;
    end else if (run_en) begin
      run_left_q <= run_left_d;
    end
  end

  assign req_valid   = valid_q;
  assign req_addr    = addr_q;
  assign req_is_read = read_q;
  assign req_size    = blk_bytes;

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_is_read))); // R10
  AST_RUN_RANGE: assert property (@(posedge clk) disable iff (!rst_n_int)
    req_valid |-> (run_left_q != '0 && run_left_q <= num_seq)); // R1
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cfg_err && !req_valid) |=> !req_valid); // R8
  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n_int)
    req_valid |-> ((req_addr & (blk_bytes - ADDR_W'(1))) == '0)); // R3
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> !req_valid); // R11

endmodule

// File: tb/dram_hit_gen_bench.sv
module dram_hit_gen_bench;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LOG_W = 5;
  localparam int unsigned STRIDE_W = 16;
  localparam int unsigned BANKS_W = 8;
  localparam int unsigned GAP_W = 8;
  localparam logic [31:0] WIN_LO = 32'h0000_1000;
  localparam logic [31:0] WIN_HI = 32'h0000_9000;
  localparam int NREQ = 24;
  localparam int LIMIT = 150000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                gen_en = 1'b0;
  logic [ADDR_W-1:0]   cfg_start_addr = WIN_LO;
  logic [ADDR_W-1:0]   cfg_end_addr = WIN_HI;
  logic [LOG_W-1:0]    cfg_block_log2 = 5'd2;
  logic [LOG_W-1:0]    cfg_page_log2 = 5'd4;
  logic [LOG_W-1:0]    cfg_bank_log2 = 5'd1;
  logic [BANKS_W-1:0]  cfg_banks_used = 8'd1;
  logic [STRIDE_W-1:0] cfg_stride_bytes = '0;
  logic [6:0]          cfg_read_pct = 7'd0;
  logic [1:0]          cfg_map_sel = 2'd0;
  logic [GAP_W-1:0]    cfg_gap_min = '0;
  logic [GAP_W-1:0]    cfg_gap_max = '0;
  logic                req_valid;
  logic                req_ready = 1'b0;
  logic [ADDR_W-1:0]   req_addr;
  logic                req_is_read;
  logic [ADDR_W-1:0]   req_size;
  logic                cfg_err;

  always #5 clk = ~clk;

  dram_hit_gen u_dram_hit_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_block_log2(cfg_block_log2), .cfg_page_log2(cfg_page_log2),
    .cfg_bank_log2(cfg_bank_log2), .cfg_banks_used(cfg_banks_used),
    .cfg_stride_bytes(cfg_stride_bytes), .cfg_read_pct(cfg_read_pct),
    .cfg_map_sel(cfg_map_sel), .cfg_gap_min(cfg_gap_min), .cfg_gap_max(cfg_gap_max),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_is_read(req_is_read), .req_size(req_size), .cfg_err(cfg_err)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int pct50_runs = 0;
  int pct50_reads = 0;

  // per-run reference state
  longint run_bank, run_row, run_col;
  bit     run_rd;
  logic [31:0] prev_a;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic check_req(input logic [31:0] a, input bit rd, input int idx,
                           input int bb, input int pb, input int kb, input int used,
                           input int mp, input int nseq, input int pct);
    int pos;
    longint bank, col, row, cols, sh;
    string tag;
    pos  = idx % nseq;
    cols = 64'(1) << pb;
    sh   = bb + pb + kb;
    if (mp == 0) begin
      bank = (a >> bb) & ((1 << kb) - 1);
      col  = (a >> (bb + kb)) & (cols - 1);
      tag  = "R6";
    end else begin
      col  = (a >> bb) & (cols - 1);
      bank = (a >> (bb + pb)) & ((1 << kb) - 1);
      tag  = (mp == 1) ? "R5" : "R7";
    end
    row = a >> sh;
    chk((a & ((1 << bb) - 1)) == 0, "R3 offset", a & ((1 << bb) - 1), 0);
    chk(row >= (WIN_LO >> sh) && row <= ((WIN_HI - 1) >> sh), "R3 row", row, WIN_LO >> sh);
    if (pos == 0) begin
      chk(req_size == (32'(1) << bb), "R3 size", req_size, 64'(1) << bb);
      chk(bank < used, "R4 bank", bank, used - 1);
      chk(col <= cols - nseq, {tag, " R4 col"}, col, cols - nseq);
      if (pct == 0)   chk(!rd, "R2 pct0", rd, 0);
      if (pct == 100) chk(rd, "R2 pct100", rd, 1);
      if (pct == 50) begin
        pct50_runs++;
        if (rd) pct50_reads++;
      end
      run_bank = bank; run_row = row; run_col = col; run_rd = rd;
    end else begin
      chk(bank == run_bank, {tag, " R1 bank"}, bank, run_bank);
      chk(row == run_row, "R1 row", row, run_row);
      chk(rd == run_rd, "R1 R2 dir", rd, run_rd);
      chk(col == run_col + 1, {tag, " R1 col"}, col, run_col + 1);
      if (mp != 0) chk(a == prev_a + (32'(1) << bb), {tag, " step"}, a, prev_a + (32'(1) << bb));
      run_col = col;
    end
    prev_a = a;
  endtask

  task automatic run_cfg(input int bb, input int pb, input int kb, input int used,
                         input int mp, input int stride, input int pct,
                         input int gmin, input int gmax);
    int nseq, got, low;
    bit after_hs, stall_prev, rdy, stall_rd;
    logic [31:0] stall_a;
    cfg_block_log2   = LOG_W'(bb);
    cfg_page_log2    = LOG_W'(bb + pb);
    cfg_bank_log2    = LOG_W'(kb);
    cfg_banks_used   = BANKS_W'(used);
    cfg_map_sel      = 2'(mp);
    cfg_stride_bytes = STRIDE_W'(stride);
    cfg_read_pct     = 7'(pct);
    cfg_gap_min      = GAP_W'(gmin);
    cfg_gap_max      = GAP_W'(gmax);
    nseq = (stride <= (1 << bb)) ? 1 : (stride + (1 << bb) - 1) / (1 << bb);
    rst_n = 1'b0; gen_en = 1'b0; req_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!req_valid, "R11 reset", req_valid, 0);
    chk(!cfg_err, "R8 legal cfg", cfg_err, 0);
    rst_n = 1'b1; gen_en = 1'b1;
    got = 0; low = 0; after_hs = 1'b0; stall_prev = 1'b0; stall_a = '0; stall_rd = 1'b0;
    while (got < NREQ) begin
      @(negedge clk);
      if (stall_prev) begin
        chk(req_valid && req_addr == stall_a && req_is_read == stall_rd, "R10 hold",
            req_addr, stall_a);
      end
      if (!req_valid) begin
        low++;
      end else if (after_hs) begin
        chk(low >= gmin + 1 && low <= gmax + 1, "R9 gap", low, gmin + 1);
        after_hs = 1'b0;
      end
      rdy = ((cyc % 5) != 2);
      req_ready = rdy;
      if (req_valid && rdy) begin
        check_req(req_addr, req_is_read, got, bb, pb, kb, used, mp, nseq, pct);
        got++;
        after_hs = 1'b1;
        low = 0;
      end
      stall_prev = req_valid && !rdy;
      stall_a = req_addr;
      stall_rd = req_is_read;
    end
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  initial begin
    int idx;
    idx = 0;
    for (int bb = 2; bb <= 3; bb++) begin
      for (int pb = 2; pb <= 3; pb++) begin
        for (int kb = 1; kb <= 2; kb++) begin
          for (int mp = 0; mp <= 3; mp++) begin
            for (int ss = 0; ss < 3; ss++) begin
              for (int us = 0; us < 2; us++) begin
                int stride, pct, gmin, gmax;
                stride = (ss == 0) ? 0 : (ss == 1) ? (1 << bb) : ((4 << bb) - 1);
                pct  = (idx % 3 == 0) ? 0 : (idx % 3 == 1) ? 100 : 50;
                gmin = (idx % 4 == 0) ? 0 : (idx % 4 == 1) ? 1 : (idx % 4 == 2) ? 2 : 0;
                gmax = (idx % 4 == 0) ? 0 : (idx % 4 == 1) ? 3 : (idx % 4 == 2) ? 2 : 5;
                run_cfg(bb, pb, kb, (us == 0) ? 1 : (1 << kb), mp, stride, pct, gmin, gmax);
                idx++;
              end
            end
          end
        end
      end
    end
    chk(pct50_reads * 5 >= pct50_runs && pct50_reads * 5 <= pct50_runs * 4,
        "R2 mix", pct50_reads, pct50_runs / 2);

    // illegal configurations: too many banks, zero banks
    for (int k = 0; k < 2; k++) begin
      int seen;
      cfg_block_log2 = 5'd2; cfg_page_log2 = 5'd4; cfg_bank_log2 = 5'd1;
      cfg_banks_used = (k == 0) ? 8'd3 : 8'd0;
      rst_n = 1'b0; gen_en = 1'b0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1; gen_en = 1'b1; req_ready = 1'b1;
      seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (req_valid) seen++;
      end
      chk(cfg_err, "R8 flag", cfg_err, 1);
      chk(seen == 0, "R8 quiet", seen, 0);
    end
    finish_run();
  end

endmodule